// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills the two connection memories of a time-slot switch with a known pattern in a single hardware pass. One memory serves the backplane side; the other is the low half of the local-side memory. Software first enables the block-program mode through a control register. It then writes the two pattern fields and the start bit into an initialization register. From the following clock the block steps through every address of both memories together, one address per clock. Each word gets its own pattern in a fixed bit slice and zeros in all other bits. When the last address has been written, the start bit clears itself.

The block drives the write ports of both memories. While no sweep is running, ordinary processor writes pass through to whichever memory is selected. While a sweep is running, those writes are dropped, so the memories always end up holding exactly the swept pattern.

Top module: `cm_block_init`

## Requirements
- R1: After reset the control and initialization registers read as zero, `busy` is low and neither memory write enable is asserted.
- R2: The control register (`reg_sel`=0) holds the block-program mode flag in bit 0. The initialization register (`reg_sel`=1) holds the start flag in bit 0, the local-low pattern in bits 6:3 and the backplane pattern in bits 9:7. All other bits read as zero.
- R3: Writing the initialization register with bit 0 set while the mode flag is 1 starts a sweep on the next clock. From that edge `busy` is high, the start flag reads 1 and address 0 of both memories is being written.
- R4: Writing the start flag while the mode flag is 0 has no effect on the sweep. The start flag stays 0, `busy` stays low and no memory write occurs.
- R5: During a sweep, every backplane address from 0 to BP_DEPTH-1 is written exactly once, in ascending order, one per clock. Each such word carries initialization bits 9:7 in bits 13:11 and zero in every other bit.
- R6: During a sweep, every local-low address from 0 to LO_DEPTH-1 is written exactly once. Each such word carries initialization bits 6:3 in bits 15:12 and zero in every other bit.
- R7: Both memories are swept at the same time, and in any clock where both are written they receive the same address.
- R8: A sweep lasts exactly max(BP_DEPTH, LO_DEPTH) clocks, which is no more than two frame periods (2*FRAME_CYCLES). After the last address, `busy` falls and the start flag reads 0.
- R9: Processor memory writes are dropped while `busy` is high. When `busy` is low, they appear in the same cycle on the memory chosen by `cpu_mem_sel` (0 = backplane, 1 = local low), and the other memory is not written.
- R10: Writes to the initialization register while a sweep runs are ignored. The patterns and the start flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 initialization |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cpu_mem_wr_en | input | 1 | Processor connection-memory write strobe |
| cpu_mem_sel | input | 1 | Target memory: 0 backplane, 1 local low |
| cpu_mem_addr | input | CPU_AW | Processor memory address |
| cpu_mem_wdata | input | 16 | Processor memory write data |
| bp_we | output | 1 | Backplane memory write enable |
| bp_addr | output | BP_AW | Backplane memory address |
| bp_wdata | output | 16 | Backplane memory write data |
| lo_we | output | 1 | Local-low memory write enable |
| lo_addr | output | LO_AW | Local-low memory address |
| lo_wdata | output | 16 | Local-low memory write data |
| busy | output | 1 | High while a sweep is in progress |

## Verification
Sweeps are run over memories pre-filled with all ones, using three pattern pairs: mixed (5 and A), all ones (7 and F) and all zeros. Between them, these catch slices that are swapped, shifted or truncated, as well as stale bits that a sweep fails to clear. One sweep is disturbed by a colliding processor write and by a register rewrite carrying different patterns. The per-address hit counts and final contents show whether either disturbance got through. A start attempt with the mode flag low, and a processor write while idle, separate the gating of the sweep from the pass-through path.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  localparam int WORD_W      = 16;
  localparam int BP_PAT_W    = 3;
  localparam int LO_PAT_W    = 4;
  localparam int CTL_MODE_B  = 0;
  localparam int INIT_GO_B   = 0;
  localparam int INIT_LO_LSB = 3;
  localparam int INIT_BP_LSB = 7;
  localparam int BP_SLOT_LSB = 11;
  localparam int LO_SLOT_LSB = 12;
  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_INIT  = 1'b1;

  function automatic logic [WORD_W-1:0] mk_bp_word(input logic [BP_PAT_W-1:0] pat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BP_SLOT_LSB +: BP_PAT_W] = pat;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] mk_lo_word(input logic [LO_PAT_W-1:0] pat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LO_SLOT_LSB +: LO_PAT_W] = pat;
    return w;
  endfunction
endpackage

// File: rtl/cmi_regs.sv
module cmi_regs
  import cmi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                sel,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                done,
  output logic                mode,
  output logic                start,
  output logic [BP_PAT_W-1:0] bp_pat,
  output logic [LO_PAT_W-1:0] lo_pat,
  output logic                go,
  output logic [WORD_W-1:0]   rdata
);
  logic                mode_q, mode_d;
  logic                start_q, start_d;
  logic [BP_PAT_W-1:0] bp_pat_q, bp_pat_d;
  logic [LO_PAT_W-1:0] lo_pat_q, lo_pat_d;
  logic                ctl_wr, init_wr;

  assign ctl_wr  = wr_en && (sel == SEL_CTRL);
  assign init_wr = wr_en && (sel == SEL_INIT) && !start_q;
  assign go      = init_wr && wdata[INIT_GO_B] && mode_q;

  always_comb begin
    mode_d   = mode_q;
    start_d  = start_q;
    bp_pat_d = bp_pat_q;
    lo_pat_d = lo_pat_q;
    if (ctl_wr) mode_d = wdata[CTL_MODE_B];
    if (init_wr) begin
      bp_pat_d = wdata[INIT_BP_LSB +: BP_PAT_W];
      lo_pat_d = wdata[INIT_LO_LSB +: LO_PAT_W];
    end
    if (done)    start_d = 1'b0;
    else if (go) start_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      start_q  <= 1'b0;
      bp_pat_q <= '0;
      lo_pat_q <= '0;
    end else begin
      mode_q   <= mode_d;
      start_q  <= start_d;
      bp_pat_q <= bp_pat_d;
      lo_pat_q <= lo_pat_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_CTRL) begin
      rdata[CTL_MODE_B] = mode_q;
    end else begin
      rdata[INIT_GO_B]                 = start_q;
      rdata[INIT_LO_LSB +: LO_PAT_W]   = lo_pat_q;
      rdata[INIT_BP_LSB +: BP_PAT_W]   = bp_pat_q;
    end
  end

  assign mode   = mode_q;
  assign start  = start_q;
  assign bp_pat = bp_pat_q;
  assign lo_pat = lo_pat_q;

  AST_GO_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(mode_q)); // R4
  AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && $past(start_q)) |-> ($stable(bp_pat_q) && $stable(lo_pat_q))); // R10
endmodule

// File: rtl/cmi_sweep.sv
module cmi_sweep #(
  parameter int SWEEP_LEN = 512,
  localparam int CW = $clog2(SWEEP_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          run,
  output logic          done,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(SWEEP_LEN - 1);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = run_q && (cnt_q == LAST);
  assign cnt_en = go || run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (go) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (done) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run = run_q;
  assign cnt = cnt_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R5
endmodule

// File: rtl/cmi_wmux.sv
module cmi_wmux
  import cmi_pkg::*;
#(
  parameter int BP_DEPTH = 512,
  parameter int LO_DEPTH = 512,
  parameter int CW       = 10,
  localparam int BP_AW   = $clog2(BP_DEPTH),
  localparam int LO_AW   = $clog2(LO_DEPTH),
  localparam int CPU_AW  = (BP_AW > LO_AW) ? BP_AW : LO_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [CW-1:0]       cnt,
  input  logic [BP_PAT_W-1:0] bp_pat,
  input  logic [LO_PAT_W-1:0] lo_pat,
  input  logic                cpu_wr,
  input  logic                cpu_sel,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]   cpu_data,
  output logic                bp_we,
  output logic [BP_AW-1:0]    bp_addr,
  output logic [WORD_W-1:0]   bp_wdata,
  output logic                lo_we,
  output logic [LO_AW-1:0]    lo_addr,
  output logic [WORD_W-1:0]   lo_wdata
);
  localparam logic [CW:0] BP_LIM = (CW+1)'(BP_DEPTH);
  localparam logic [CW:0] LO_LIM = (CW+1)'(LO_DEPTH);

  logic bp_in_range, lo_in_range;

  assign bp_in_range = ({1'b0, cnt} < BP_LIM);
  assign lo_in_range = ({1'b0, cnt} < LO_LIM);

  always_comb begin
    if (run) begin
      bp_we    = bp_in_range;
      bp_addr  = cnt[BP_AW-1:0];
      bp_wdata = mk_bp_word(bp_pat);
      lo_we    = lo_in_range;
      lo_addr  = cnt[LO_AW-1:0];
      lo_wdata = mk_lo_word(lo_pat);
    end else begin
      bp_we    = cpu_wr && !cpu_sel;
      bp_addr  = cpu_addr[BP_AW-1:0];
      bp_wdata = cpu_data;
      lo_we    = cpu_wr && cpu_sel;
      lo_addr  = cpu_addr[LO_AW-1:0];
      lo_wdata = cpu_data;
    end
  end

  AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_we && lo_we) |-> (CPU_AW'(bp_addr) == CPU_AW'(lo_addr))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cpu_wr) |-> (!bp_we && !lo_we)); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> $onehot0({bp_we, lo_we})); // R9
endmodule

// File: rtl/cm_block_init.sv
module cm_block_init
  import cmi_pkg::*;
#(
  parameter int BP_DEPTH     = 512,
  parameter int LO_DEPTH     = 512,
  parameter int FRAME_CYCLES = 1024,
  localparam int BP_AW       = $clog2(BP_DEPTH),
  localparam int LO_AW       = $clog2(LO_DEPTH),
  localparam int CPU_AW      = (BP_AW > LO_AW) ? BP_AW : LO_AW,
  localparam int SWEEP_LEN   = (BP_DEPTH > LO_DEPTH) ? BP_DEPTH : LO_DEPTH,
  localparam int CW          = $clog2(SWEEP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              cpu_mem_wr_en,
  input  logic              cpu_mem_sel,
  input  logic [CPU_AW-1:0] cpu_mem_addr,
  input  logic [15:0]       cpu_mem_wdata,
  output logic              bp_we,
  output logic [BP_AW-1:0]  bp_addr,
  output logic [15:0]       bp_wdata,
  output logic              lo_we,
  output logic [LO_AW-1:0]  lo_addr,
  output logic [15:0]       lo_wdata,
  output logic              busy
);
  logic                rst_meta_q, rst_sync_q;
  logic                mode, start, go, done, run;
  logic [BP_PAT_W-1:0] bp_pat;
  logic [LO_PAT_W-1:0] lo_pat;
  logic [CW-1:0]       cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cmi_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .wr_en  (reg_wr_en),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .done   (done),
    .mode   (mode),
    .start  (start),
    .bp_pat (bp_pat),
    .lo_pat (lo_pat),
    .go     (go),
    .rdata  (reg_rdata)
  );

  cmi_sweep #(.SWEEP_LEN(SWEEP_LEN)) u_sweep (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .go    (go),
    .run   (run),
    .done  (done),
    .cnt   (cnt)
  );

  cmi_wmux #(.BP_DEPTH(BP_DEPTH), .LO_DEPTH(LO_DEPTH), .CW(CW)) u_wmux (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (run),
    .cnt      (cnt),
    .bp_pat   (bp_pat),
    .lo_pat   (lo_pat),
    .cpu_wr   (cpu_mem_wr_en),
    .cpu_sel  (cpu_mem_sel),
    .cpu_addr (cpu_mem_addr),
    .cpu_data (cpu_mem_wdata),
    .bp_we    (bp_we),
    .bp_addr  (bp_addr),
    .bp_wdata (bp_wdata),
    .lo_we    (lo_we),
    .lo_addr  (lo_addr),
    .lo_wdata (lo_wdata)
  );

  assign busy = run;

  int unsigned run_len_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  run_len_q <= 0;
    else if (run)     run_len_q <= run_len_q + 1;
    else              run_len_q <= 0;
  end

  AST_BUSY_TRACKS_START: assert property (@(posedge clk) disable iff (!rst_sync_q)
    start == run); // R8
  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_q)
    run |-> (run_len_q < 2 * FRAME_CYCLES)); // R8
  AST_NO_GO_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!mode && !run) |=> !run); // R4
endmodule

// File: tb/cm_block_init_tb.sv
module cm_block_init_tb;
  localparam int BPD = 512;
  localparam int LOD = 512;
  localparam int AW  = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_en, reg_sel;
  logic [15:0]   reg_wdata, reg_rdata;
  logic          cpu_mem_wr_en, cpu_mem_sel;
  logic [AW-1:0] cpu_mem_addr;
  logic [15:0]   cpu_mem_wdata;
  logic          bp_we, lo_we, busy;
  logic [AW-1:0] bp_addr, lo_addr;
  logic [15:0]   bp_wdata, lo_wdata;

  int errors = 0;
  int checks = 0;

  logic [15:0] bp_mem [BPD];
  logic [15:0] lo_mem [LOD];
  int bp_hits [BPD];
  int lo_hits [LOD];
  int busy_cycles, order_err, addr_mismatch, bp_next, lo_next, idle_writes;

  always #5 clk = ~clk;

  cm_block_init u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_mem_wr_en(cpu_mem_wr_en), .cpu_mem_sel(cpu_mem_sel),
    .cpu_mem_addr(cpu_mem_addr), .cpu_mem_wdata(cpu_mem_wdata),
    .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
    .lo_we(lo_we), .lo_addr(lo_addr), .lo_wdata(lo_wdata),
    .busy(busy)
  );

  always @(negedge clk) begin
    #2;
    if (busy) busy_cycles++;
    if (!busy && (bp_we || lo_we)) idle_writes++;
    if (busy && bp_we && lo_we && (bp_addr != lo_addr)) addr_mismatch++;
    if (bp_we) begin
      bp_mem[bp_addr] = bp_wdata;
      bp_hits[bp_addr]++;
      if (busy) begin
        if (int'(bp_addr) != bp_next) order_err++;
        bp_next++;
      end
    end
    if (lo_we) begin
      lo_mem[lo_addr] = lo_wdata;
      lo_hits[lo_addr]++;
      if (busy) begin
        if (int'(lo_addr) != lo_next) order_err++;
        lo_next++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic clear_model();
    for (int i = 0; i < BPD; i++) begin bp_mem[i] = 16'hFFFF; bp_hits[i] = 0; end
    for (int i = 0; i < LOD; i++) begin lo_mem[i] = 16'hFFFF; lo_hits[i] = 0; end
    busy_cycles = 0; order_err = 0; addr_mismatch = 0; bp_next = 0; lo_next = 0; idle_writes = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_contents(input logic [2:0] bp, input logic [3:0] lo, input string tag);
    int bad_bp = 0, bad_lo = 0, bad_bh = 0, bad_lh = 0;
    for (int i = 0; i < BPD; i++) begin
      if (bp_mem[i] != {2'b00, bp, 11'd0}) bad_bp++;
      if (bp_hits[i] != 1) bad_bh++;
    end
    for (int i = 0; i < LOD; i++) begin
      if (lo_mem[i] != {lo, 12'd0}) bad_lo++;
      if (lo_hits[i] != 1) bad_lh++;
    end
    check(bad_bp == 0, {"R5 bp words ", tag}, bad_bp, 0);
    check(bad_bh == 0, {"R5 bp once ", tag}, bad_bh, 0);
    check(order_err == 0, {"R5 order ", tag}, order_err, 0);
    check(bad_lo == 0, {"R6 lo words ", tag}, bad_lo, 0);
    check(bad_lh == 0, {"R6 lo once ", tag}, bad_lh, 0);
    check(addr_mismatch == 0, {"R7 same addr ", tag}, addr_mismatch, 0);
    check(busy_cycles == 512, {"R8 length ", tag}, busy_cycles, 512);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    reg_read(1'b0, d); check(d == 16'h0, "R1 ctrl", d, 0);
    reg_read(1'b1, d); check(d == 16'h0, "R1 init", d, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(!bp_we && !lo_we, "R1 we", {bp_we, lo_we}, 0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    reg_write(1'b0, 16'hFFFF);
    reg_read(1'b0, d); check(d == 16'h0001, "R2 ctrl", d, 16'h0001);
    reg_write(1'b0, 16'h0000);
    reg_write(1'b1, 16'hFC06 | (16'h5 << 7) | (16'hA << 3));
    reg_read(1'b1, d); check(d == ((16'h5 << 7) | (16'hA << 3)), "R2 init", d, (16'h5 << 7) | (16'hA << 3));
  endtask

  task automatic t_no_mode();
    logic [15:0] d;
    clear_model();
    reg_write(1'b0, 16'h0000);
    reg_write(1'b1, 16'h0001 | (16'h7 << 7));
    reg_read(1'b1, d); check(d[0] == 1'b0, "R4 start", d[0], 0);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R4 busy", busy, 0);
    check(idle_writes == 0 && busy_cycles == 0, "R4 writes", idle_writes, 0);
  endtask

  task automatic t_sweep(input logic [2:0] bp, input logic [3:0] lo, input bit disturb, input string tag);
    logic [15:0] d;
    clear_model();
    reg_write(1'b0, 16'h0001);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0001 | (16'(bp) << 7) | (16'(lo) << 3);
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
    check(busy == 1'b1, {"R3 busy ", tag}, busy, 1);
    check(bp_we && lo_we && bp_addr == 0 && lo_addr == 0, {"R3 first addr ", tag}, bp_addr, 0);
    reg_read(1'b1, d); check(d[0] == 1'b1, {"R3 start ", tag}, d[0], 1);
    if (disturb) begin
      repeat (50) @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0001 | (16'(~bp) << 7) | (16'(~lo) << 3);
      cpu_mem_wr_en = 1'b1; cpu_mem_sel = 1'b0; cpu_mem_addr = 9'd100; cpu_mem_wdata = 16'h1234;
      @(negedge clk);
      reg_wr_en = 1'b0;
      cpu_mem_sel = 1'b1; cpu_mem_addr = 9'd300;
      @(negedge clk);
      cpu_mem_wr_en = 1'b0;
      reg_read(1'b1, d);
      check(d[9:3] == {bp, lo}, "R10 init held", d[9:3], {bp, lo});
    end
    wait_idle();
    reg_read(1'b1, d); check(d == ((16'(bp) << 7) | (16'(lo) << 3)), {"R8 start clear ", tag}, d, (16'(bp) << 7) | (16'(lo) << 3));
    check(busy == 1'b0, {"R8 busy low ", tag}, busy, 0);
    check_contents(bp, lo, tag);
    if (disturb) check(bp_mem[100] != 16'h1234 && lo_mem[300] != 16'h1234, "R9 blocked", bp_mem[100], {2'b00, bp, 11'd0});
  endtask

  task automatic t_passthrough();
    @(negedge clk);
    cpu_mem_wr_en = 1'b1; cpu_mem_sel = 1'b0; cpu_mem_addr = 9'd7; cpu_mem_wdata = 16'hBEEF;
    #1;
    check(bp_we && !lo_we && bp_addr == 9'd7 && bp_wdata == 16'hBEEF, "R9 bp pass", bp_wdata, 16'hBEEF);
    @(negedge clk);
    cpu_mem_sel = 1'b1; cpu_mem_addr = 9'd511; cpu_mem_wdata = 16'h0F0F;
    #1;
    check(lo_we && !bp_we && lo_addr == 9'd511 && lo_wdata == 16'h0F0F, "R9 lo pass", lo_wdata, 16'h0F0F);
    @(negedge clk);
    cpu_mem_wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    cpu_mem_wr_en = 1'b0; cpu_mem_sel = 1'b0; cpu_mem_addr = '0; cpu_mem_wdata = '0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_no_mode();
    t_sweep(3'h5, 4'hA, 1'b0, "mixed");
    t_sweep(3'h7, 4'hF, 1'b1, "ones");
    t_sweep(3'h0, 4'h0, 1'b0, "zeros");
    t_passthrough();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule